// File: doc/BRIEF.md
# Fractional-Rate Serial Transceiver Engine

This block is the serial engine behind a small memory-mapped serial port. A register bank in front of it hands over a 32-bit rate setting, a transmit byte together with a single-cycle load pulse, and a single-cycle acknowledge pulse that the receive byte has been taken. In return the engine reports whether the transmitter is still shifting, whether a received byte is waiting, and what that byte is.

Bit timing comes from a 16-bit phase accumulator, not from a divide-by-N counter. Every clock the accumulator adds the rate setting, and each carry out of its top bit is one oversampling tick. The host picks the setting so that ticks arrive eight times per bit. In the common case the rate is not an integer fraction of the clock, and the accumulator spreads the remainder evenly across ticks. The transmitter sends standard frames: one start bit, eight data bits and one stop bit. The receiver oversamples the line, checks the start bit for validity, reads each data bit at the middle of its window and checks the stop bit.

Top module: `uart_acc_core`

## Requirements
- R1: Every clock the accumulator adds the low 16 bits of the rate setting, or 0xFFFF if any of bits 31:16 are set. Each carry out of bit 15 is one tick, and one bit period lasts 8 ticks. A full transmit frame therefore keeps the busy flag high for between 79 and 80 tick periods of 65536/setting clocks.
- R2: The serial output idles at 1. A frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit.
- R3: The busy flag reads 1 from the cycle after an accepted load until the stop bit has been sent in full, then reads 0.
- R4: A load pulse that arrives while busy is 1 is ignored. The byte in progress is unchanged, and no further frame follows it.
- R5: After a valid frame on the serial input, the ready flag is 1 and the received byte holds the frame's data bits, with bit 0 being the first bit sent.
- R6: A low pulse on the serial input that has ended before the fourth tick after its falling edge is treated as noise. The receiver returns to idle and the ready flag is not set.
- R7: A frame whose stop bit samples 0 is dropped. The ready flag and the received byte are not changed.
- R8: If a second valid frame finishes while ready is still 1, the new byte replaces the old one and ready stays at 1.
- R9: An acknowledge pulse clears ready in the following cycle, unless a frame completes in the same cycle.
- R10: A synchronous active-high reset clears the accumulator and both state machines, drives the serial output to 1, and clears busy and ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_set | input | 32 | Accumulator increment, held steady by the host |
| tx_load | input | 1 | Single-cycle pulse: start sending tx_byte |
| tx_byte | input | 8 | Byte to transmit |
| rx_ack | input | 1 | Single-cycle pulse: received byte has been taken |
| rxd | input | 1 | Serial input line, asynchronous |
| txd | output | 1 | Serial output line |
| tx_busy | output | 1 | Transmitter is shifting a frame |
| rx_ready | output | 1 | A received byte is waiting |
| rx_byte | output | 8 | Last valid received byte |

## Verification
A bad accumulator value shows up only as timing drift. It appears first as a busy period longer or shorter than 79 to 80 ticks, about one frame time after the load. Bit sampling errors then follow over the next frames. A transmitter that loses its place gives a wrong bit or a misplaced stop level within one bit period, or a busy flag that falls late. A receiver state fault shows up at the end of the frame: the ready flag is set when it should not be, or is missing, or the byte is shifted by one position. The bench therefore samples every bit near its middle and checks both flags immediately after each frame.

// File: rtl/uart_acc_pkg.sv
package uart_acc_pkg;
  localparam int ACC_WIDTH  = 16;
  localparam int OVERSAMPLE = 8;
  localparam int DATA_BITS  = 8;
  localparam int SET_WIDTH  = 32;

  typedef enum logic [1:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_acc_tick.sv
module uart_acc_tick #(
  parameter int ACC_W = uart_acc_pkg::ACC_WIDTH,
  parameter int SET_W = uart_acc_pkg::SET_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rate_set,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_eff;
  logic [ACC_W:0]   sum;

  // settings beyond the accumulator range saturate
  assign inc_eff = (|rate_set[SET_W-1:ACC_W]) ? {ACC_W{1'b1}} : rate_set[ACC_W-1:0];
  assign sum     = {1'b0, acc_q} + {1'b0, inc_eff};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      tick  <= sum[ACC_W];
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !inc_eff[ACC_W-1] && $stable(rate_set)) |=> !tick);
endmodule

// File: rtl/uart_acc_tx.sv
module uart_acc_tx
  import uart_acc_pkg::*;
#(
  parameter int OSR = OVERSAMPLE,
  parameter int DW  = DATA_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_B = BW'(DW - 1);

  tx_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW-1:0] sh;
  logic          bit_end;

  assign bit_end = tick && (cnt == LAST_T);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= TX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      txd  <= 1'b1;
      busy <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      case (st)
        TX_IDLE: begin
          if (load) begin
            sh   <= data;
            txd  <= 1'b0;
            busy <= 1'b1;
            cnt  <= '0;
            st   <= TX_START;
          end
        end
        TX_START: begin
          if (bit_end) begin
            cnt <= '0;
            idx <= '0;
            txd <= sh[0];
            sh  <= sh >> 1;
            st  <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == LAST_B) begin
              txd <= 1'b1;
              st  <= TX_STOP;
            end else begin
              txd <= sh[0];
              sh  <= sh >> 1;
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          if (bit_end) begin
            cnt  <= '0;
            busy <= 1'b0;
            st   <= TX_IDLE;
          end
        end
      endcase
    end
  end

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R3
  busy_ends_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(st) == TX_STOP);
  // R4
  load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && load && st != TX_STOP) |=> busy && $stable(idx));
endmodule

// File: rtl/uart_acc_rx.sv
module uart_acc_rx
  import uart_acc_pkg::*;
#(
  parameter int OSR = OVERSAMPLE,
  parameter int DW  = DATA_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          ack,
  output logic          ready,
  output logic [DW-1:0] rx_data
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
  localparam logic [CW-1:0] MID_T  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] LAST_B = BW'(DW - 1);

  rx_state_e     st;
  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW-1:0] sh;
  logic          bit_mid;
  logic          done_ok;

  assign bit_mid = tick && (cnt == LAST_T);
  assign done_ok = (st == RX_STOP) && bit_mid && s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      s3      <= 1'b1;
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      ready   <= 1'b0;
      rx_data <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
      if (ack) ready <= 1'b0;
      if (tick) cnt <= cnt + 1'b1;
      case (st)
        RX_IDLE: begin
          if (s3 && !s2) begin
            cnt <= '0;
            st  <= RX_START;
          end
        end
        RX_START: begin
          if (tick && cnt == MID_T) begin
            cnt <= '0;
            idx <= '0;
            st  <= s2 ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (bit_mid) begin
            cnt <= '0;
            sh  <= {s2, sh[DW-1:1]};
            if (idx == LAST_B) st <= RX_STOP;
            else idx <= idx + 1'b1;
          end
        end
        default: begin
          if (bit_mid) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end
          if (done_ok) begin
            rx_data <= sh;
            ready   <= 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(s2) && $past(st) == RX_STOP);
  // R8
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !ack) |=> ready);
  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !(st == RX_STOP && tick)) |=> !ready);
  // R6
  start_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && tick && cnt == MID_T && s2) |=> st == RX_IDLE && $stable(ready));
endmodule

// File: rtl/uart_acc_core.sv
module uart_acc_core
  import uart_acc_pkg::*;
#(
  parameter int ACC_W = ACC_WIDTH,
  parameter int SET_W = SET_WIDTH,
  parameter int OSR   = OVERSAMPLE,
  parameter int DW    = DATA_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rate_set,
  input  logic             tx_load,
  input  logic [DW-1:0]    tx_byte,
  input  logic             rx_ack,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_busy,
  output logic             rx_ready,
  output logic [DW-1:0]    rx_byte
);
  logic tick;

  uart_acc_tick #(.ACC_W(ACC_W), .SET_W(SET_W)) u_tick (
    .clk(clk), .rst(rst), .rate_set(rate_set), .tick(tick)
  );

  uart_acc_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .data(tx_byte),
    .txd(txd), .busy(tx_busy)
  );

  uart_acc_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .ack(rx_ack),
    .ready(rx_ready), .rx_data(rx_byte)
  );

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> txd && !tx_busy && !rx_ready);
endmodule

// File: tb/tb_uart_acc_core.sv
`timescale 1ns/1ps
module tb_uart_acc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rate_set = 32'd8192;
  logic        tx_load = 1'b0;
  logic [7:0]  tx_byte = 8'h00;
  logic        rx_ack = 1'b0;
  logic        rxd = 1'b1;
  logic        txd, tx_busy, rx_ready;
  logic [7:0]  rx_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  real tper, bitp;
  int  pbit;

  always #2.5 clk = ~clk;

  uart_acc_core dut (
    .clk(clk), .rst(rst), .rate_set(rate_set), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_ack(rx_ack), .rxd(rxd), .txd(txd),
    .tx_busy(tx_busy), .rx_ready(rx_ready), .rx_byte(rx_byte)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic real tick_period(input logic [31:0] s);
    return 65536.0 / real'(s);
  endfunction

  task automatic set_rate(input logic [31:0] s);
    rate_set = s;
    tper = tick_period(s);
    bitp = 8.0 * tper;
    pbit = $rtoi(bitp + 0.5);
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit ign, input logic [7:0] other);
    int cyc;
    int tgt;
    int bn;
    int lim;
    bit saw_low;
    logic [9:0] got;
    @(negedge clk);
    tx_byte = b;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    cyc = 0;
    chk(tx_busy == 1'b1, "R3 busy after load", 32'(tx_busy), 32'd1);
    for (int k = 0; k < 10; k++) begin
      tgt = $rtoi(bitp * (real'(k) + 0.5) - tper * 0.5);
      while (cyc < tgt) begin
        @(negedge clk);
        cyc++;
        if (ign && cyc == 20) begin
          tx_byte = other;
          tx_load = 1'b1;
        end else begin
          tx_load = 1'b0;
        end
      end
      got[k] = txd;
    end
    tx_load = 1'b0;
    chk(got[0] == 1'b0, "R2 start bit", 32'(got[0]), 32'd0);
    chk(got[8:1] == b, "R2 data bits", 32'(got[8:1]), 32'(b));
    chk(got[9] == 1'b1, "R2 stop bit", 32'(got[9]), 32'd1);
    bn  = cyc;
    lim = $rtoi(bitp * 12.0);
    while (tx_busy && bn < lim) begin
      @(negedge clk);
      bn++;
    end
    chk(bn >= $rtoi(79.0 * tper) - 1 && bn <= $rtoi(80.0 * tper) + 2,
        "R1 frame length", 32'(bn), 32'($rtoi(80.0 * tper)));
    chk(tx_busy == 1'b0, "R3 busy clears", 32'(tx_busy), 32'd0);
    if (ign) begin
      saw_low = 0;
      for (int i = 0; i < 2 * pbit; i++) begin
        @(negedge clk);
        if (!txd || tx_busy) saw_low = 1;
      end
      chk(!saw_low, "R4 no second frame", 32'(saw_low), 32'd0);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
    logic [9:0] f;
    f = {stop_lvl, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rxd = f[k];
      repeat (pbit) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_pulse();
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  initial begin
    logic [7:0] a, c;
    logic [31:0] s;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    set_rate(32'd8192);
    repeat (4) @(negedge clk);
    // R10: state during and after reset
    chk(txd == 1'b1 && !tx_busy && !rx_ready, "R10 in reset",
        {29'd0, txd, tx_busy, rx_ready}, 32'd4);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && !tx_busy && !rx_ready, "R10 after reset",
        {29'd0, txd, tx_busy, rx_ready}, 32'd4);

    // directed transmit corners at an exact 64-clock bit
    tx_frame(8'h00, 0, 8'h00);
    tx_frame(8'hFF, 0, 8'h00);
    tx_frame(8'hA5, 1, 8'h3C);   // R4

    // directed receive corners
    send_rx(8'h81, 1'b1);
    chk(rx_ready == 1'b1, "R5 ready set", 32'(rx_ready), 32'd1);
    chk(rx_byte == 8'h81, "R5 byte", 32'(rx_byte), 32'h81);
    ack_pulse();
    chk(rx_ready == 1'b0, "R9 ack clears", 32'(rx_ready), 32'd0);

    // R6: short low pulse
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * pbit) @(negedge clk);
    chk(rx_ready == 1'b0, "R6 glitch ignored", 32'(rx_ready), 32'd0);
    send_rx(8'h5A, 1'b1);
    chk(rx_ready && rx_byte == 8'h5A, "R6 recovers", 32'(rx_byte), 32'h5A);
    ack_pulse();

    // R7: bad stop bit
    send_rx(8'hC3, 1'b0);
    repeat (pbit) @(negedge clk);
    chk(rx_ready == 1'b0, "R7 ready not set", 32'(rx_ready), 32'd0);
    chk(rx_byte == 8'h5A, "R7 byte kept", 32'(rx_byte), 32'h5A);

    // R8: overwrite without ack
    send_rx(8'h11, 1'b1);
    send_rx(8'hE7, 1'b1);
    chk(rx_ready == 1'b1, "R8 ready stays", 32'(rx_ready), 32'd1);
    chk(rx_byte == 8'hE7, "R8 newest byte", 32'(rx_byte), 32'hE7);
    ack_pulse();
    chk(rx_ready == 1'b0, "R9 ack clears again", 32'(rx_ready), 32'd0);

    // R1: saturated setting, one tick per clock
    set_rate(32'h0001_0000);
    tper = 65536.0 / 65535.0;
    bitp = 8.0 * tper;
    pbit = 8;
    tx_frame(8'h96, 0, 8'h00);

    // random bytes over fractional settings
    for (int r = 0; r < 8; r++) begin
      s = 32'd4096 + ($urandom % 32'd4096);
      set_rate(s);
      repeat (2 * pbit) @(negedge clk);
      a = 8'($urandom);
      c = 8'($urandom);
      tx_frame(a, (r % 3) == 0, c);
      send_rx(c, 1'b1);
      chk(rx_ready == 1'b1, "R5 random ready", 32'(rx_ready), 32'd1);
      chk(rx_byte == c, "R5 random byte", 32'(rx_byte), 32'(c));
      ack_pulse();
      chk(rx_ready == 1'b0, "R9 random ack", 32'(rx_ready), 32'd0);
    end
    summary();
  end
endmodule